// File: doc/BRIEF.md
# EEPROM write-protect controller

This block keeps the protection state of a small serial EEPROM and decides, cycle by cycle, whether a write to the memory array or to the status register may go ahead. It holds the write-enable latch, the lock-enable flag and the three block-protect bits. It decodes the protected address region from those bits and applies the rules that combine the latch, the lock-enable flag and the active-low write-protect pin. The status byte that a read command returns is assembled here.

A serial front end, outside this block, turns commands into pulses: set or clear the enable latch, and request a write (array or status) together with an address and a data byte. An accepted request is armed. It launches an internal write cycle of a fixed length when chip select is deasserted. A status write that is still armed can be cancelled by the write-protect pin. Block-protect and lock-enable values change only when a status write cycle completes.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x60, and both `arr_ok` and `sts_ok` are 0.
- R2: The status byte is laid out as bit 7 lock-enable, bits 6:5 constant 1, bits 4:2 block-protect code, bit 1 enable latch, bit 0 busy (1 while an internal write cycle runs).
- R3: `arr_ok` is 0 for every address inside the region picked by the block-protect code, whatever the latch holds. The codes are: 0 none; 1 to 4 the four quarters in rising order (0x00-0x3F, 0x40-0x7F, 0x80-0xBF, 0xC0-0xFF); 5 the lower half 0x00-0x7F; 6 the first 16 bytes 0x00-0x0F; 7 the last 16 bytes 0xF0-0xFF.
- R4: For an address outside the region, `arr_ok` equals the enable latch, whatever the lock-enable flag and `wp_n` hold.
- R5: `sts_ok` is 1 exactly when the latch is 1 and either lock-enable is 0 or `wp_n` is 1.
- R6: A `wel_set` pulse sets the latch one cycle later and a `wel_clr` pulse clears it; clear wins when both are pulsed together. `wel_set` is ignored while busy.
- R7: A write request is armed only when its permission (`arr_ok` for array, `sts_ok` for status) is 1. A refused request starts no cycle and leaves the status byte unchanged.
- R8: A rising edge of `cs_n` while a request is armed raises busy in the next cycle. Busy stays set for WCYC cycles. When it drops, the latch is cleared and, for a status write, the new lock-enable and block-protect values appear.
- R9: A status write takes only data bits 7 and 4:2. Data bits 6:5, 1 and 0 have no effect on the status byte.
- R10: The region decode uses the committed block-protect code. A new code has no effect while its write is armed or busy.
- R11: When lock-enable is 1 and a status write is armed, a falling `wp_n` while `cs_n` is low cancels it: `sts_abort` pulses for one cycle, and the following `cs_n` rise starts no cycle. With lock-enable 0, a `wp_n` fall cancels nothing.
- R12: A `wp_n` fall in the same cycle as the `cs_n` rise, or during the internal cycle, does not stop the write.
- R13: `wr_req` is ignored while a request is armed or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; its rising edge launches an armed write |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Pulse: set the write-enable latch |
| wel_clr | input | 1 | Pulse: clear the write-enable latch |
| wr_req | input | 1 | Pulse: write request |
| wr_to_status | input | 1 | 1 for a status write, 0 for an array write |
| wr_addr | input | AW | Target array address |
| wr_data | input | 8 | New status byte for a status write |
| arr_ok | output | 1 | Array write at `wr_addr` is allowed |
| sts_ok | output | 1 | Status write is allowed |
| sts_abort | output | 1 | One-cycle pulse: an armed status write was cancelled |
| status_q | output | 8 | Status byte as read back |

## Verification
The cancel path and the launch path share one trigger window. A `wp_n` fall and a `cs_n` rise can land on the same clock edge while a status write is armed. The bench drives both on one edge and expects the write to launch with no cancel pulse and to commit its block-protect code. It then repeats the fall with `cs_n` still low and expects a cancel pulse, no busy, and an unchanged status byte.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic {
        WK_ARRAY  = 1'b0,
        WK_STATUS = 1'b1
    } wr_kind_e;

    typedef enum logic [2:0] {
        BPZ_NONE    = 3'd0,
        BPZ_Q1      = 3'd1,
        BPZ_Q2      = 3'd2,
        BPZ_Q3      = 3'd3,
        BPZ_Q4      = 3'd4,
        BPZ_LOWHALF = 3'd5,
        BPZ_HEAD16  = 3'd6,
        BPZ_TAIL16  = 3'd7
    } bp_zone_e;

    // Writable part of the status byte
    typedef struct packed {
        logic       wpen;
        logic [2:0] bp;
    } prot_cfg_t;

    // Read-back layout of the status byte, MSB first
    typedef struct packed {
        logic       wpen;
        logic [1:0] ones;
        logic [2:0] bp;
        logic       wel;
        logic       rdy;
    } stat_word_t;

    localparam int SMALL_BLK = 16;

    function automatic stat_word_t pack_status(prot_cfg_t c, logic wel, logic rdy);
        stat_word_t s;
        s.wpen = c.wpen;
        s.ones = 2'b11;
        s.bp   = c.bp;
        s.wel  = wel;
        s.rdy  = rdy;
        return s;
    endfunction

    function automatic prot_cfg_t take_cfg(logic [7:0] d);
        prot_cfg_t c;
        c.wpen = d[7];
        c.bp   = d[4:2];
        return c;
    endfunction

endpackage

// File: rtl/wprot_zone.sv
module wprot_zone
    import wprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  bp_zone_e        zone,
    input  logic [AW-1:0]   addr,
    output logic            hit
);
    localparam int LOWB = $clog2(SMALL_BLK);

    logic [3:0] qhit;
    logic       head;
    logic       tail;
    logic       unused_low;

    for (genvar q = 0; q < 4; q++) begin : g_quarter
        assign qhit[q] = (addr[AW-1:AW-2] == 2'(q));
    end

    assign head       = (addr[AW-1:LOWB] == '0);
    assign tail       = &addr[AW-1:LOWB];
    assign unused_low = ^addr[LOWB-1:0];

    always_comb begin
        case (zone)
            BPZ_NONE:    hit = 1'b0;
            BPZ_Q1:      hit = qhit[0];
            BPZ_Q2:      hit = qhit[1];
            BPZ_Q3:      hit = qhit[2];
            BPZ_Q4:      hit = qhit[3];
            BPZ_LOWHALF: hit = !addr[AW-1];
            BPZ_HEAD16:  hit = head;
            BPZ_TAIL16:  hit = tail;
            default:     hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_p,
    input  logic clr_p,
    input  logic busy,
    input  logic done,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
        end else if (done || clr_p) begin
            wel <= 1'b0;
        end else if (set_p && !busy) begin
            wel <= 1'b1;
        end
    end
endmodule

// File: rtl/wprot_wcycle.sv
module wprot_wcycle
    import wprot_pkg::*;
#(
    parameter int WCYC = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      wp_n,
    input  logic      lock_en,
    input  logic      accept,
    input  wr_kind_e  acc_kind,
    input  prot_cfg_t acc_cfg,
    output logic      armed,
    output logic      busy,
    output logic      done,
    output wr_kind_e  done_kind,
    output prot_cfg_t held_cfg,
    output logic      abort_p
);
    localparam int CW = $clog2(WCYC + 1);

    logic [CW-1:0] cnt;
    logic          cs_q;
    logic          wp_q;
    wr_kind_e      kind_q;
    logic          cs_rise;
    logic          wp_fall;
    logic          kill;
    logic          launch;

    assign cs_rise   = cs_n && !cs_q;
    assign wp_fall   = !wp_n && wp_q;
    // cancel needs chip select still low, so it never meets a launch
    assign kill      = armed && (kind_q == WK_STATUS) && !cs_n && lock_en && wp_fall;
    assign launch    = armed && cs_rise;
    assign done      = busy && (cnt == '0);
    assign done_kind = kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= 1'b1;
            wp_q     <= 1'b1;
            armed    <= 1'b0;
            busy     <= 1'b0;
            cnt      <= '0;
            kind_q   <= WK_ARRAY;
            held_cfg <= '0;
            abort_p  <= 1'b0;
        end else begin
            cs_q    <= cs_n;
            wp_q    <= wp_n;
            abort_p <= kill;

            if (accept) begin
                armed    <= 1'b1;
                kind_q   <= acc_kind;
                held_cfg <= acc_cfg;
            end else if (kill || launch) begin
                armed <= 1'b0;
            end

            if (launch) begin
                busy <= 1'b1;
                cnt  <= CW'(WCYC - 1);
            end else if (done) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int AW   = 8,
    parameter int WCYC = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          wp_n,
    input  logic          wel_set,
    input  logic          wel_clr,
    input  logic          wr_req,
    input  logic          wr_to_status,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          arr_ok,
    output logic          sts_ok,
    output logic          sts_abort,
    output logic [7:0]    status_q
);
    prot_cfg_t cfg_q;
    prot_cfg_t held_cfg;
    wr_kind_e  req_kind;
    wr_kind_e  done_kind;
    logic      wel;
    logic      armed;
    logic      busy;
    logic      done;
    logic      hit;
    logic      accept;
    logic      unused_data;

    assign req_kind    = wr_to_status ? WK_STATUS : WK_ARRAY;
    assign unused_data = ^{wr_data[6:5], wr_data[1:0]};

    wprot_zone #(.AW(AW)) zone_i (
        .zone (bp_zone_e'(cfg_q.bp)),
        .addr (wr_addr),
        .hit  (hit)
    );

    assign arr_ok = wel && !hit;
    assign sts_ok = wel && (!cfg_q.wpen || wp_n);
    assign accept = wr_req && !armed && !busy &&
                    ((req_kind == WK_STATUS) ? sts_ok : arr_ok);

    wprot_wel wel_i (
        .clk   (clk),
        .rst   (rst),
        .set_p (wel_set),
        .clr_p (wel_clr),
        .busy  (busy),
        .done  (done),
        .wel   (wel)
    );

    wprot_wcycle #(.WCYC(WCYC)) cyc_i (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wp_n      (wp_n),
        .lock_en   (cfg_q.wpen),
        .accept    (accept),
        .acc_kind  (req_kind),
        .acc_cfg   (take_cfg(wr_data)),
        .armed     (armed),
        .busy      (busy),
        .done      (done),
        .done_kind (done_kind),
        .held_cfg  (held_cfg),
        .abort_p   (sts_abort)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (done && (done_kind == WK_STATUS)) begin
            cfg_q <= held_cfg;
        end
    end

    assign status_q = pack_status(cfg_q, wel, busy);

endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       arr_ok,
    input logic       sts_ok,
    input logic       sts_abort,
    input logic [7:0] status_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_q == 8'h60));

    // R2
    fixed_ones_chk: assert property (@(posedge clk) disable iff (rst)
        status_q[6:5] == 2'b11);

    // R4
    wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !status_q[1] |-> (!arr_ok && !sts_ok));

    // R5
    sts_rule_chk: assert property (@(posedge clk) disable iff (rst)
        sts_ok == (status_q[1] && (!status_q[7] || wp_n)));

    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status_q[0]) |-> !status_q[1]);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(status_q[0]) |-> $stable({status_q[7], status_q[4:2]}));

    // R11
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sts_abort |=> !sts_abort);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sts_abort |-> !status_q[0]);
endmodule

bind wprot_ctrl wprot_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wp_n      (wp_n),
    .arr_ok    (arr_ok),
    .sts_ok    (sts_ok),
    .sts_abort (sts_abort),
    .status_q  (status_q)
);

// File: tb/wprot_ctrl_tb.sv
module wprot_ctrl_tb_top;
    localparam int AW   = 8;
    localparam int WCYC = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          wel_set = 1'b0;
    logic          wel_clr = 1'b0;
    logic          wr_req = 1'b0;
    logic          wr_to_status = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          arr_ok;
    logic          sts_ok;
    logic          sts_abort;
    logic [7:0]    status_q;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    // bench model of the committed state
    bit       m_wpen = 0;
    bit [2:0] m_bp = 0;
    bit       m_wel = 0;

    always #4 clk = ~clk;

    wprot_ctrl #(.AW(AW), .WCYC(WCYC)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .wel_set(wel_set), .wel_clr(wel_clr), .wr_req(wr_req),
        .wr_to_status(wr_to_status), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_ok(arr_ok), .sts_ok(sts_ok), .sts_abort(sts_abort),
        .status_q(status_q)
    );

    function automatic bit exp_prot(int code, int a);
        case (code)
            1, 2, 3, 4: return (a / 64) == (code - 1);
            5:          return a < 128;
            6:          return a < 16;
            7:          return a >= 240;
            default:    return 0;
        endcase
    endfunction

    function automatic [7:0] exp_status(bit rdy);
        return m_wpen * 128 + 96 + m_bp * 4 + m_wel * 2 + rdy;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_wel();
        wel_set = 1'b1;
        tick();
        wel_set = 1'b0;
        m_wel = 1;
    endtask

    // Arms a status write (cs_n low); caller decides what happens next
    task automatic arm_status(input bit wp, input [2:0] b, input [7:0] junk);
        cs_n = 1'b0;
        wr_req = 1'b1;
        wr_to_status = 1'b1;
        wr_data = {wp, 2'b00, b, 2'b00} | junk;
        tick();
        wr_req = 1'b0;
    endtask

    // cs_n rise after an armed write; checks busy window and commit
    task automatic fire_and_finish(string req, input bit is_status, input bit wp, input [2:0] b);
        cs_n = 1'b1;
        tick();
        chk({req, " busy raised"}, status_q[0], 1);
        repeat (WCYC - 1) tick();
        chk({req, " busy held WCYC cycles"}, status_q[0], 1);
        tick();
        m_wel = 0;
        if (is_status) begin
            m_wpen = wp;
            m_bp = b;
        end
        chk({req, " commit status"}, status_q, exp_status(0));
    endtask

    task automatic write_status(input bit wp, input [2:0] b, input [7:0] junk);
        pulse_wel();
        arm_status(wp, b, junk);
        fire_and_finish("R8 R9 R2", 1, wp, b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 status", status_q, 8'h60);
        chk("R1 arr_ok", arr_ok, 0);
        chk("R1 sts_ok", sts_ok, 0);

        // R6 latch set, R5 with lock-enable 0
        pulse_wel();
        chk("R6 wel set", status_q, exp_status(0));
        wp_n = 1'b0; #1;
        chk("R5 wpen0 wp low", sts_ok, 1);
        wp_n = 1'b1; #1;
        chk("R5 wpen0 wp high", sts_ok, 1);
        // R6 clear wins over set
        wel_set = 1'b1; wel_clr = 1'b1;
        tick();
        wel_set = 1'b0; wel_clr = 1'b0;
        m_wel = 0;
        chk("R6 clear wins", status_q, exp_status(0));

        // R7 refused status write with latch 0
        arm_status(1, 3'd7, 8'h00);
        cs_n = 1'b1;
        repeat (WCYC + 2) tick();
        chk("R7 refused status write", status_q, exp_status(0));

        // R3 R4 R9 sweep of every code and address
        for (int code = 0; code < 8; code++) begin
            write_status(0, 3'(code), 8'h63);
            pulse_wel();
            for (int wp = 0; wp < 2; wp++) begin
                for (int a = 0; a < 256; a++) begin
                    wp_n = wp[0];
                    wr_addr = 8'(a);
                    #1;
                    chk("R3 R4 region decode", arr_ok, exp_prot(code, a) ? 0 : 1);
                end
            end
            wp_n = 1'b1;
            wel_clr = 1'b1;
            tick();
            wel_clr = 1'b0;
            m_wel = 0;
            wr_addr = 8'h33; #1;
            chk("R4 latch 0 blocks array", arr_ok, 0);
        end

        // R10: code 7 committed, arm code 0; old region still applies
        pulse_wel();
        arm_status(0, 3'd0, 8'h00);
        wr_addr = 8'hF8; #1;
        chk("R10 armed keeps old region", arr_ok, 0);
        cs_n = 1'b1;
        tick();
        chk("R10 busy keeps old region", arr_ok, 0);
        repeat (WCYC) tick();
        m_wel = 0; m_bp = 0;
        chk("R10 commit", status_q, exp_status(0));
        pulse_wel();
        #1;
        chk("R10 new region applies", arr_ok, 1);

        // lock-enable on
        write_status(1, 3'd0, 8'h00);
        pulse_wel();
        wp_n = 1'b1; #1;
        chk("R5 wpen1 wp high", sts_ok, 1);
        wp_n = 1'b0; #1;
        chk("R5 wpen1 wp low", sts_ok, 0);
        wr_addr = 8'h05; #1;
        chk("R4 array unaffected by lock", arr_ok, 1);
        arm_status(1, 3'd5, 8'h00);
        cs_n = 1'b1;
        repeat (WCYC + 2) tick();
        chk("R7 locked status write refused", status_q, exp_status(0));

        // R11 cancel with cs_n low
        wp_n = 1'b1;
        tick();
        arm_status(1, 3'd3, 8'h00);
        wp_n = 1'b0;
        tick();
        chk("R11 abort pulse", sts_abort, 1);
        tick();
        chk("R11 abort single cycle", sts_abort, 0);
        cs_n = 1'b1;
        repeat (WCYC + 2) tick();
        chk("R11 no cycle after cancel", status_q, exp_status(0));

        // R12 wp_n fall on the cs_n rise edge
        wp_n = 1'b1;
        tick();
        arm_status(1, 3'd2, 8'h00);
        cs_n = 1'b1;
        wp_n = 1'b0;
        tick();
        chk("R12 no abort on launch edge", sts_abort, 0);
        chk("R12 launched", status_q[0], 1);
        repeat (WCYC) tick();
        m_wel = 0; m_wpen = 1; m_bp = 2;
        chk("R12 write completed", status_q, exp_status(0));

        // R13 and R6: requests and latch set ignored while busy
        wp_n = 1'b1;
        tick();
        pulse_wel();
        cs_n = 1'b0;
        wr_req = 1'b1; wr_to_status = 1'b0; wr_addr = 8'h10;
        tick();
        wr_req = 1'b0;
        cs_n = 1'b1;
        tick();
        chk("R8 array write busy", status_q[0], 1);
        cs_n = 1'b0;
        wr_req = 1'b1; wr_to_status = 1'b1; wr_data = 8'h94;
        wel_set = 1'b1;
        tick();
        wr_req = 1'b0; wel_set = 1'b0;
        cs_n = 1'b1;
        repeat (WCYC + 3) tick();
        m_wel = 0;
        chk("R13 R6 busy ignores request and set", status_q, exp_status(0));

        // R11 negative: lock-enable 0, wp_n fall does not cancel
        write_status(0, 3'd0, 8'h00);
        pulse_wel();
        arm_status(0, 3'd1, 8'h00);
        wp_n = 1'b0;
        tick();
        chk("R11 no abort with wpen0", sts_abort, 0);
        fire_and_finish("R11 wpen0 write proceeds", 1, 0, 3'd1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule